// File: doc/BRIEF.md
# Load/Store Alignment and Byte Lane Unit

This unit sits between the load/store stage of a processor core and a 64-bit data memory port. The core hands it one access at a time: a byte address, a size code (8, 16, 32 or 64 bits), a flag selecting sign or zero extension for loads, a per-access flag selecting big- or little-endian byte numbering, and, for stores, the datum right-aligned in a 64-bit word. The unit first checks natural alignment. A misaligned access is never sent to memory. Instead the unit raises a one-cycle trap and reports the faulting address.

For an aligned store, the unit places the datum on the byte lanes that the address selects under the chosen endianness and drives one byte enable per lane. For an aligned load, it takes the returned 64-bit word, picks out the addressed bytes in the right significance order, and widens the result to 64 bits with sign or zero fill.

Control is a four-state machine:
- `ST_IDLE` accepts a request.
- `ST_ISSUE` holds the memory request until it is acknowledged.
- `ST_RESPOND` presents the result for one cycle.
- `ST_FAULT` presents the trap for one cycle.

Transitions:
- IDLE→ISSUE on an aligned request.
- IDLE→FAULT on a misaligned request.
- ISSUE→ISSUE while `mem_ack` is low.
- ISSUE→RESPOND on `mem_ack`.
- RESPOND→IDLE and FAULT→IDLE unconditionally.

Top module: `lsu_lane_unit`

## Requirements
- R1: `req_size` encodes the access width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. An issued request has exactly 2^size byte enables set.
- R2: An access of n bytes whose address is not a multiple of n is not issued: `mem_valid` and `mem_be` stay zero. One cycle after acceptance, `trap_valid` is high for exactly one cycle, with `trap_addr` equal to the request address.
- R3: A byte access never traps, whatever its low address bits.
- R4: In little-endian mode (`req_big_endian` = 0), the byte at address offset k within the 8-byte word uses lane k (bits 8k+7:8k). The datum's least significant byte goes to the lowest addressed byte.
- R5: In big-endian mode (`req_big_endian` = 1), the byte at offset k uses lane 7−k. The datum's most significant byte goes to the lowest addressed byte.
- R6: A load with `req_signed` = 0 returns the addressed bytes with all upper bits zero.
- R7: A load with `req_signed` = 1 copies the top bit of the loaded datum into every upper bit of the 64-bit result. A 64-bit load is returned unchanged.
- R8: `req_ready` is high only in IDLE. While `mem_valid` is high and `mem_ack` is low, `mem_addr`, `mem_be`, `mem_write` and `mem_wdata` hold their values into the next cycle.
- R9: `rsp_valid` is high for one cycle, in the cycle after the one in which `mem_ack` was high. `rsp_rdata` holds the load result, or zero for a store.
- R10: After reset, `req_ready` is 1 and `mem_valid`, `mem_be`, `rsp_valid` and `trap_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Unit can accept an access (IDLE) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (R1) |
| req_signed | input | 1 | Sign-extend load result |
| req_big_endian | input | 1 | Big-endian lane numbering |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store datum, right-aligned |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a store |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_be | output | 8 | Byte enables, one per lane |
| mem_wdata | output | 64 | Store data on its lanes |
| mem_ack | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | 64 | Load data, valid with mem_ack |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_rdata | output | 64 | Extended load result |
| trap_valid | output | 1 | Alignment trap pulse |
| trap_addr | output | ADDR_W | Faulting address |

## Verification
Some properties are checked by assertions on every cycle:
- an issued request has a byte enable count that matches its size code;
- a pending request stays stable until it is acknowledged;
- a trap lasts exactly one cycle and is never accompanied by a memory request;
- a response appears only in the cycle after an acknowledge.

Lane placement under each endianness, the content of store data, sign versus zero fill, and the trap address are checked only by the bench scenarios. The bench compares these against a byte-by-byte model, using seeded random accesses and directed edge offsets.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESPOND,
        ST_FAULT
    } lsu_state_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check #(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output logic             misaligned
);
    // an access of 2^size bytes needs its low "size" address bits clear
    always_comb begin
        misaligned = 1'b0;
        for (int i = 0; i < OFF_W; i++) begin
            if (i < int'(size)) misaligned = misaligned | offset[i];
        end
    end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
    parameter int LANES = 8,
    parameter int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]   offset,
    input  logic [1:0]         size,
    input  logic               big_endian,
    input  logic [8*LANES-1:0] wdata,
    output logic [OFF_W-1:0]   lane_shift,
    output logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] lane_wdata
);
    localparam int SPAN_W = OFF_W + 1;

    logic [SPAN_W-1:0]  nbytes;
    logic [SPAN_W-1:0]  shift_full;
    logic [LANES-1:0]   keep;
    logic [8*LANES-1:0] masked;

    // little endian: datum starts at lane "offset";
    // big endian: datum ends at lane LANES-1-offset
    always_comb begin
        nbytes     = SPAN_W'(1) << size;
        shift_full = big_endian ? (SPAN_W'(LANES) - SPAN_W'(offset) - nbytes)
                                : SPAN_W'(offset);
        lane_shift = shift_full[OFF_W-1:0];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_keep
        assign keep[g]          = (SPAN_W'(g) < nbytes);
        assign masked[8*g +: 8] = keep[g] ? wdata[8*g +: 8] : 8'h00;
    end

    assign be         = keep << lane_shift;
    assign lane_wdata = masked << {lane_shift, 3'b000};
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
    parameter int LANES = 8,
    parameter int OFF_W = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] rdata,
    input  logic [OFF_W-1:0]   lane_shift,
    input  logic [1:0]         size,
    input  logic               sign_ext,
    output logic [8*LANES-1:0] value
);
    localparam int SPAN_W = OFF_W + 1;

    logic [8*LANES-1:0] shifted;
    logic [SPAN_W-1:0]  nbytes;
    logic               top_bit;

    assign shifted = rdata >> {lane_shift, 3'b000};
    assign nbytes  = SPAN_W'(1) << size;

    always_comb begin
        top_bit = 1'b0;
        for (int b = 0; b < LANES; b++) begin
            if (SPAN_W'(b + 1) == nbytes) top_bit = shifted[8*b + 7];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_fill
        assign value[8*g +: 8] = (SPAN_W'(g) < nbytes) ? shifted[8*g +: 8]
                                                      : {8{sign_ext & top_bit}};
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic                req_big_endian,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [8*LANES-1:0]  req_wdata,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LANES-1:0]    mem_be,
    output logic [8*LANES-1:0]  mem_wdata,
    input  logic                mem_ack,
    input  logic [8*LANES-1:0]  mem_rdata,
    output logic                rsp_valid,
    output logic [8*LANES-1:0]  rsp_rdata,
    output logic                trap_valid,
    output logic [ADDR_W-1:0]   trap_addr
);
    localparam int OFF_W  = $clog2(LANES);
    localparam int DATA_W = 8 * LANES;

    lsu_state_e state_q, state_d;

    logic               wr_q, sgn_q;
    logic [1:0]         size_q;
    logic [ADDR_W-1:0]  addr_q, trap_addr_q;
    logic [LANES-1:0]   be_q;
    logic [DATA_W-1:0]  wdata_q, rsp_q;
    logic [OFF_W-1:0]   shift_q;

    logic               misaligned;
    logic [OFF_W-1:0]   map_shift;
    logic [LANES-1:0]   map_be;
    logic [DATA_W-1:0]  map_wdata, load_value;
    logic               accept;

    lsu_align_check #(.OFF_W(OFF_W)) i_align (
        .offset     (req_addr[OFF_W-1:0]),
        .size       (req_size),
        .misaligned (misaligned)
    );

    lsu_lane_map #(.LANES(LANES), .OFF_W(OFF_W)) i_map (
        .offset     (req_addr[OFF_W-1:0]),
        .size       (req_size),
        .big_endian (req_big_endian),
        .wdata      (req_wdata),
        .lane_shift (map_shift),
        .be         (map_be),
        .lane_wdata (map_wdata)
    );

    lsu_load_extract #(.LANES(LANES), .OFF_W(OFF_W)) i_extract (
        .rdata      (mem_rdata),
        .lane_shift (shift_q),
        .size       (size_q),
        .sign_ext   (sgn_q),
        .value      (load_value)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = misaligned ? ST_FAULT : ST_ISSUE;
            ST_ISSUE:   if (mem_ack)   state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request, trap and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q        <= 1'b0;
            sgn_q       <= 1'b0;
            size_q      <= 2'd0;
            addr_q      <= '0;
            be_q        <= '0;
            wdata_q     <= '0;
            shift_q     <= '0;
            trap_addr_q <= '0;
            rsp_q       <= '0;
        end else begin
            if (accept && !misaligned) begin
                wr_q    <= req_write;
                sgn_q   <= req_signed;
                size_q  <= req_size;
                addr_q  <= req_addr;
                be_q    <= map_be;
                wdata_q <= req_write ? map_wdata : '0;
                shift_q <= map_shift;
            end
            if (accept && misaligned) trap_addr_q <= req_addr;
            if (state_q == ST_ISSUE && mem_ack) rsp_q <= wr_q ? '0 : load_value;
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        mem_valid  = 1'b0;
        rsp_valid  = 1'b0;
        trap_valid = 1'b0;
        mem_be     = '0;
        unique case (state_q)
            ST_IDLE:    req_ready  = 1'b1;
            ST_ISSUE:   begin mem_valid = 1'b1; mem_be = be_q; end
            ST_RESPOND: rsp_valid  = 1'b1;
            ST_FAULT:   trap_valid = 1'b1;
            default:    req_ready  = 1'b0;
        endcase
    end

    assign mem_write = wr_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rsp_rdata = rsp_q;
    assign trap_addr = trap_addr_q;

    // enable count produced by the lane mapper matches the registered size code
    assert_be_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == (1 << size_q)));

    // trap is a single-cycle pulse with no memory traffic
    assert_trap_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (!mem_valid && mem_be == '0) ##1 !trap_valid);

    // pending request is frozen until acknowledged
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                     && $stable(mem_wdata) && $stable(mem_write)));

    // response only in the cycle following an acknowledge
    assert_rsp_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(mem_ack) && $past(mem_valid)));
endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, req_big_endian = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, mem_valid, mem_write, rsp_valid, trap_valid;
    logic [31:0] mem_addr, trap_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata, rsp_rdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    lsu_lane_unit #(.ADDR_W(32), .LANES(8)) i_lsu_lane_unit (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_size, .req_signed,
        .req_big_endian, .req_addr, .req_wdata, .mem_valid, .mem_write, .mem_addr,
        .mem_be, .mem_wdata, .mem_ack, .mem_rdata, .rsp_valid, .rsp_rdata,
        .trap_valid, .trap_addr
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lane_of(input bit big, input int byte_off);
        return big ? 7 - byte_off : byte_off;
    endfunction

    function automatic logic [7:0] exp_be(input int n, input int off, input bit big);
        logic [7:0] be = '0;
        for (int k = 0; k < n; k++) be[lane_of(big, off + k)] = 1'b1;
        return be;
    endfunction

    // byte at address offset off+k holds datum byte k (LE) or n-1-k (BE)
    function automatic logic [63:0] exp_store(input int n, input int off, input bit big,
                                              input logic [63:0] d);
        logic [63:0] w = '0;
        for (int k = 0; k < n; k++) begin
            int src = big ? n - 1 - k : k;
            w[8*lane_of(big, off + k) +: 8] = d[8*src +: 8];
        end
        return w;
    endfunction

    function automatic logic [63:0] exp_load(input int n, input int off, input bit big,
                                             input bit sgn, input logic [63:0] r);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) begin
            int dst = big ? n - 1 - k : k;
            v[8*dst +: 8] = r[8*lane_of(big, off + k) +: 8];
        end
        if (sgn && n < 8 && v[8*n-1]) begin
            for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
        end
        return v;
    endfunction

    // called right after a negedge with the unit idle; returns after a negedge, idle again
    task automatic access(input bit wr, input int sz, input bit sgn, input bit big,
                          input logic [31:0] addr, input logic [63:0] wd,
                          input logic [63:0] rd, input int delay);
        int n   = 1 << sz;
        int off = int'(addr[2:0]);
        bit bad = (addr % n) != 0;
        logic [7:0] ebe = exp_be(n, off, big);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_signed = sgn;
        req_big_endian = big; req_addr = addr; req_wdata = wd;
        chk("R8 ready in idle", {63'd0, req_ready}, 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk("R2 trap pulse", {63'd0, trap_valid}, 64'd1);
            chk("R2 trap address", {32'd0, trap_addr}, {32'd0, addr});
            chk("R2 no request", {55'd0, mem_valid, mem_be}, 64'd0);
            @(negedge clk);
            chk("R2 trap ends", {62'd0, trap_valid, mem_valid}, 64'd0);
            chk("R8 back to ready", {63'd0, req_ready}, 64'd1);
        end else begin
            chk(sz == 0 ? "R3 byte not trapped" : "R2 aligned not trapped",
                {62'd0, trap_valid, mem_valid}, 64'd1);
            chk(big ? "R5 byte enables" : "R4 byte enables", {56'd0, mem_be}, {56'd0, ebe});
            chk("R1 address/write", {31'd0, mem_write, mem_addr}, {31'd0, wr, addr});
            if (wr) chk(big ? "R5 store lanes" : "R4 store lanes", mem_wdata,
                        exp_store(n, off, big, wd));
            chk("R8 ready low while busy", {63'd0, req_ready}, 64'd0);
            for (int i = 0; i < delay; i++) begin
                @(negedge clk);
                chk("R8 request held", {55'd0, mem_valid, mem_be}, {55'd0, 1'b1, ebe});
            end
            mem_ack = 1'b1; mem_rdata = rd;
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = $urandom;
            chk("R9 response valid", {62'd0, rsp_valid, mem_valid}, 64'd2);
            if (wr) chk("R9 store result zero", rsp_rdata, 64'd0);
            else    chk(sgn ? "R7 signed load" : "R6 unsigned load", rsp_rdata,
                        exp_load(n, off, big, sgn, rd));
            @(negedge clk);
            chk("R9 response one cycle", {62'd0, rsp_valid, req_ready}, 64'd1);
        end
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {52'd0, req_ready, mem_valid, rsp_valid, trap_valid, mem_be},
            {52'd0, 1'b1, 11'd0});
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        access(1, 0, 0, 0, 32'h107, 64'h0000_0000_0000_00A5, 0, 0);                 // R3 R4
        access(1, 0, 0, 1, 32'h107, 64'h0000_0000_0000_00A5, 0, 0);                 // R5
        access(1, 1, 0, 1, 32'h206, 64'h0000_0000_0000_BEEF, 0, 2);                 // R5
        access(0, 2, 1, 0, 32'h304, 0, 64'h8765_4321_0000_0000, 0);                 // R7
        access(0, 2, 0, 0, 32'h304, 0, 64'h8765_4321_0000_0000, 1);                 // R6
        access(0, 2, 1, 1, 32'h300, 0, 64'hF123_4567_89AB_CDEF, 0);                 // R7 BE
        access(0, 3, 1, 1, 32'h408, 0, 64'h8000_0000_0000_0001, 3);                 // R7 64-bit
        access(0, 0, 1, 0, 32'h503, 0, 64'h0000_0000_8000_0000, 0);                 // R3 R7
        access(1, 3, 0, 0, 32'h600, 64'h0123_4567_89AB_CDEF, 0, 0);                 // R1
        access(1, 1, 0, 0, 32'h701, 64'h1234, 0, 0);                                // R2
        access(0, 2, 0, 1, 32'h702, 0, 0, 0);                                       // R2
        access(1, 3, 0, 0, 32'h704, 64'h1, 0, 0);                                   // R2
        // seeded random mix
        for (int t = 0; t < 400; t++) begin
            int sz = $urandom % 4;
            logic [31:0] a = $urandom;
            if (($urandom % 5) != 0) a = a & ~((32'd1 << sz) - 1);
            access($urandom % 2, sz, $urandom % 2, $urandom % 2, a,
                   {$urandom, $urandom}, {$urandom, $urandom}, $urandom % 3);
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule